// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Engine

This block moves one 16-bit word per machine cycle between a CPU pipeline and an external memory over a single shared address/data bus. The fast clock `clk_i` runs at four times the machine rate. A free-running 2-bit slot counter divides each machine cycle into four slots:

- **Slot 0, strobe:** the address goes out and the address-latch strobe is high.
- **Slot 1, hold:** the strobe is low but the address stays on the bus, which gives the external latch its hold time.
- **Slot 2, transfer:** the bus carries data.
- **Slot 3, capture:** the bus still carries data, and load data is taken at the edge that closes this slot.

The CPU presents a request, a store flag, an address and store data, and holds them through slot 3. The engine takes a request only at the edge that closes slot 3, and runs the transfer in the machine cycle that follows.

- **Load:** the engine releases the bus in slots 2 and 3 and raises a read strobe. It captures the memory's data at the close of slot 3, then presents it with a one-fast-cycle done pulse.
- **Store:** the engine replaces the address with the store data in slot 2 and raises a write strobe for slots 2 and 3.

With parameter `WRITE_EN` set to 0, the same engine serves as an instruction fetch port. In that mode the store flag is ignored and every request is a read.

Top module: `mux_bus_if`

## Requirements
- R1: After reset, `bus_oe_o`, `ale_o`, `rd_o`, `wr_o` and `done_o` are low, and `phase_o` is 0.
- R2: `phase_o` counts 0,1,2,3 repeatedly (0 strobe, 1 hold, 2 transfer, 3 capture). A request is taken only when `req_i` is high at the rising edge that ends slot 3. A request that is high only in slots 0 to 2 starts nothing.
- R3: In slot 0 of an active cycle, `ale_o` is high, `bus_oe_o` is high and `bus_o` equals the latched address. In slot 1, `ale_o` is low while `bus_o` and `bus_oe_o` keep the address on the bus.
- R4: For a load, `bus_oe_o` is low and `rd_o` is high in slots 2 and 3.
- R5: Load data is taken from `bus_i` at the edge ending slot 3. It appears on `rdata_o`, and `done_o` is high for exactly slot 0 of the next machine cycle.
- R6: For a store, `bus_o` equals the store data with `bus_oe_o` high in slots 2 and 3, and `wr_o` is high in those two slots only.
- R7: A store also produces a single-slot `done_o` pulse in slot 0 of the next machine cycle.
- R8: `rd_o` and `wr_o` are never high together. With no request, `bus_oe_o`, `ale_o`, `rd_o` and `wr_o` stay low.
- R9: With `WRITE_EN`=0, `we_i` is ignored: `wr_o` never rises, and a request with `we_i` high behaves as a load.
- R10: Requests held in consecutive machine cycles run back to back, with no idle cycle between them. The done pulse of one transfer coincides with the strobe of the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, four per machine cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, sampled at end of slot 3 |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | 16 | Word address |
| wdata_i | input | 16 | Store data |
| rdata_o | output | 16 | Captured load data |
| done_o | output | 1 | One-slot completion pulse |
| bus_o | output | 16 | Value driven onto the shared bus |
| bus_oe_o | output | 1 | Bus driver enable (low = high impedance) |
| bus_i | input | 16 | Value read from the shared bus |
| ale_o | output | 1 | Address-latch strobe; latch on its fall |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| phase_o | output | 2 | Current slot within the machine cycle |

## Verification
The hardest situation to reach is the slot-0 overlap of back-to-back transfers. There, the done pulse and captured data of one transfer must be checked against the earlier scoreboard entry, while the address strobe of the next transfer pops a new one. The driver reaches it by issuing a load, a store and another load in consecutive machine cycles.

The memory model drives a marker value on `bus_i` whenever the read strobe is low. A capture at the wrong edge therefore returns the marker instead of the address-derived data.

A request pulse confined to slots 1 and 2 probes the sampling window. A second instance with writes disabled is given a store request.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {
    SLOT_STROBE = 2'd0,
    SLOT_HOLD   = 2'd1,
    SLOT_XFER   = 2'd2,
    SLOT_CAPT   = 2'd3
  } slot_e;
endpackage

// File: rtl/mux_bus_slot_cnt.sv
module mux_bus_slot_cnt
  import mux_bus_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  output slot_e slot_o,
  output logic  last_o
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= 2'd0;
    else         cnt_q <= cnt_q + 2'd1;
  end

  assign slot_o = slot_e'(cnt_q);
  assign last_o = (cnt_q == 2'd3);
endmodule

// File: rtl/mux_bus_sel_reg.sv
// Two-source holding register; selects must be mutually exclusive.
module mux_bus_sel_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel0_i,
  input  logic         sel1_i,
  input  logic [W-1:0] d0_i,
  input  logic [W-1:0] d1_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (sel0_i) q_o <= d0_i;
    else if (sel1_i) q_o <= d1_i;
  end
endmodule

// File: rtl/mux_bus_if.sv
module mux_bus_if
  import mux_bus_pkg::*;
#(
  parameter int DW       = 16,
  parameter bit WRITE_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  input  logic [DW-1:0] bus_i,
  output logic          ale_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [1:0]    phase_o
);
  slot_e slot;
  logic  last;
  logic  act_q, st_q, oe_q, done_q;
  logic  [DW-1:0] wd_q, rd_q;
  logic  start, sel_data;

  mux_bus_slot_cnt u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .slot_o (slot),
    .last_o (last)
  );

  assign start    = last & req_i;
  assign sel_data = act_q & st_q & (slot == SLOT_HOLD);

  mux_bus_sel_reg #(.W(DW)) u_bus_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel0_i (start),
    .sel1_i (sel_data),
    .d0_i   (addr_i),
    .d1_i   (wd_q),
    .q_o    (bus_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      st_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= last & act_q;
      if (last) begin
        act_q <= req_i;
        st_q  <= req_i & we_i & WRITE_EN;
        oe_q  <= req_i;
        if (req_i) wd_q <= wdata_i;
        if (act_q && !st_q) rd_q <= bus_i;  // close of capture slot
      end else if (slot == SLOT_HOLD) begin
        oe_q <= act_q & st_q;               // loads release the bus
      end
    end
  end

  assign bus_oe_o = oe_q;
  assign ale_o    = act_q & (slot == SLOT_STROBE);
  assign rd_o     = act_q & ~st_q & slot[1];
  assign wr_o     = act_q &  st_q & slot[1];
  assign done_o   = done_q;
  assign rdata_o  = rd_q;
  assign phase_o  = slot;
endmodule

// File: rtl/mux_bus_if_chk.sv
module mux_bus_if_chk #(
  parameter int DW       = 16,
  parameter bit WRITE_EN = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic          ale_o,
  input logic          rd_o,
  input logic          wr_o,
  input logic [1:0]    phase_o
);
  AST_RD_WR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));                                          // R8
  AST_ALE_IN_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (phase_o == 2'd0) && bus_oe_o);                  // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> bus_oe_o && $stable(bus_o));                     // R3
  AST_LOAD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> !bus_oe_o && phase_o[1]);                         // R4
  AST_STORE_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> bus_oe_o && phase_o[1]);                          // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                       // R5
  AST_DONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> phase_o == 2'd0);                               // R7
  AST_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WRITE_EN == 1'b0) |-> !wr_o);                             // R9
endmodule

bind mux_bus_if mux_bus_if_chk #(.DW(DW), .WRITE_EN(WRITE_EN)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o),
  .ale_o    (ale_o),
  .rd_o     (rd_o),
  .wr_o     (wr_o),
  .phase_o  (phase_o)
);

// File: tb/mux_bus_if_tb.sv
module mux_bus_if_tb;
  localparam int DW = 16;
  localparam logic [DW-1:0] RD_KEY = 16'hA5C3;
  localparam logic [DW-1:0] IDLE_V = 16'hDEAD;

  typedef struct packed {
    logic          we;
    logic [DW-1:0] addr;
    logic [DW-1:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req = 1'b0, we = 1'b0;
  logic [DW-1:0] addr = '0, wdata = '0;
  logic [DW-1:0] rdata, bus_o, bus_i;
  logic          done, oe, ale, rd, wr;
  logic [1:0]    ph;
  logic [DW-1:0] lat_addr = '0;

  logic          f_req = 1'b0, f_we = 1'b0;
  logic [DW-1:0] f_addr = '0;
  logic [DW-1:0] f_rdata, f_bus_o, f_bus_i;
  logic          f_done, f_oe, f_ale, f_rd, f_wr;
  logic [1:0]    f_ph;
  logic [DW-1:0] f_lat = '0;

  int n_run = 0, n_fail = 0;
  item_t exp_q[$];
  item_t cur;
  logic  cur_v = 1'b0;

  mux_bus_if #(.DW(DW), .WRITE_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .bus_o(bus_o),
    .bus_oe_o(oe), .bus_i(bus_i), .ale_o(ale), .rd_o(rd), .wr_o(wr),
    .phase_o(ph));

  mux_bus_if #(.DW(DW), .WRITE_EN(1'b0)) u_ifp (
    .clk_i(clk), .rst_ni(rst_n), .req_i(f_req), .we_i(f_we), .addr_i(f_addr),
    .wdata_i(16'h1234), .rdata_o(f_rdata), .done_o(f_done), .bus_o(f_bus_o),
    .bus_oe_o(f_oe), .bus_i(f_bus_i), .ale_o(f_ale), .rd_o(f_rd), .wr_o(f_wr),
    .phase_o(f_ph));

  // memory model: drives data only while read strobe is high
  assign bus_i   = rd   ? (lat_addr ^ RD_KEY) : IDLE_V;
  assign f_bus_i = f_rd ? (f_lat ^ RD_KEY)    : IDLE_V;

  task automatic chk(input bit ok, input string req_tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (ale) lat_addr = bus_o;
      if (f_ale) f_lat = f_bus_o;
      chk(!(rd && wr), "R8 rd/wr overlap", {15'd0, rd}, {15'd0, ~wr});
      if (done) begin
        if (!cur_v) chk(1'b0, "R7 done without transfer", 16'd1, 16'd0);
        else if (cur.we) chk(1'b1, "R7", '0, '0);
        else chk(rdata == cur.data, "R5 load data", rdata, cur.data);
        cur_v = 1'b0;
      end
      if (ale) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", bus_o, '0);
        end else begin
          cur = exp_q.pop_front();
          cur_v = 1'b1;
          chk(oe && bus_o == cur.addr, "R3 address in strobe slot", bus_o, cur.addr);
        end
      end else if (cur_v && ph == 2'd1) begin
        chk(oe && bus_o == cur.addr, "R3 address held in gap", bus_o, cur.addr);
      end else if (cur_v && ph[1]) begin
        if (cur.we)
          chk(oe && wr && !rd && bus_o == cur.data, "R6 store drive", bus_o, cur.data);
        else
          chk(!oe && rd && !wr, "R4 load release", {13'd0, oe, rd, wr}, 16'h0002);
      end
    end
  end

  task automatic issue(input logic w, input logic [DW-1:0] a, input logic [DW-1:0] d);
    item_t it;
    do @(negedge clk); while (ph != 2'd3);
    req = 1'b1; we = w; addr = a; wdata = d;
    it.we = w; it.addr = a; it.data = w ? d : (a ^ RD_KEY);
    exp_q.push_back(it);
    @(negedge clk);
    req = 1'b0; we = 1'b0; addr = 16'hFFFF; wdata = 16'hFFFF;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || cur_v) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    bit idle_ok;
    repeat (3) @(negedge clk);
    chk(!oe && !ale && !rd && !wr && !done && ph == 2'd0, "R1 reset state",
        {11'd0, oe, ale, rd, wr, done}, '0);
    rst_n = 1'b1;
    // R1 / R2 slot sequence
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(ph == 2'(i + 1), "R2 slot order", {14'd0, ph}, 16'(2'(i + 1)));
    end
    // R8 idle bus
    idle_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (oe || ale || rd || wr) idle_ok = 1'b0;
    end
    chk(idle_ok, "R8 idle bus quiet", {15'd0, idle_ok}, 16'd1);
    // R2 request outside slot 3 is ignored
    do @(negedge clk); while (ph != 2'd1);
    req = 1'b1; addr = 16'h0BAD;
    @(negedge clk);
    req = 1'b0;
    idle_ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (oe || ale) idle_ok = 1'b0;
    end
    chk(idle_ok, "R2 early request ignored", {15'd0, idle_ok}, 16'd1);
    // single load and single store (R4 R5 R6 R7)
    issue(1'b0, 16'h0010, 16'h0000);
    drain();
    issue(1'b1, 16'h0020, 16'hBEEF);
    drain();
    // R10 back to back
    issue(1'b0, 16'h1234, 16'h0);
    issue(1'b1, 16'h4321, 16'hC0DE);
    issue(1'b0, 16'hFFFE, 16'h0);
    issue(1'b1, 16'h0000, 16'h0001);
    drain();
    // R9 fetch port ignores write flag
    do @(negedge clk); while (f_ph != 2'd3);
    f_req = 1'b1; f_we = 1'b1; f_addr = 16'h0777;
    @(negedge clk);
    f_req = 1'b0; f_we = 1'b0;
    chk(f_ale && f_oe && f_bus_o == 16'h0777, "R9 fetch address", f_bus_o, 16'h0777);
    @(negedge clk);
    @(negedge clk);
    chk(!f_oe && f_rd && !f_wr, "R9 fetch reads not writes",
        {13'd0, f_oe, f_rd, f_wr}, 16'h0002);
    @(negedge clk);
    chk(!f_wr && f_rd, "R9 no write strobe", {14'd0, f_rd, f_wr}, 16'h0002);
    @(negedge clk);
    chk(f_done && f_rdata == (16'h0777 ^ RD_KEY), "R9 fetch data", f_rdata,
        16'h0777 ^ RD_KEY);
    @(negedge clk);
    chk(!f_done, "R5 done single slot", {15'd0, f_done}, 16'd0);
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule